// File: doc/BRIEF.md
# Size-Selectable Negation Flag Unit

This unit takes an operand of up to 64 bits and returns its two's complement negation, which is zero minus the operand, at one of four operand sizes. A two-bit size code chooses the width. Operand bits above that width are ignored. The result comes back zero-extended to 64 bits, together with six status flags that follow a common processor convention. Carry reports that the operand was nonzero, and parity looks only at the low byte of the result.

Operation is a two-stage pipeline. A request is the operand, the size code and a valid strobe, sampled on one rising edge. The following edge registers the result and flags, and a one-cycle output valid pulse marks them. A new request may be issued on every cycle. Between results, the result and flag outputs keep their last values.

Top module: `neg_flag_unit`

## Requirements
- R1: The result output equals (0 - operand) modulo 2^N, where N is the selected size, with every bit at or above N driven to zero. Operand bits at or above N have no effect on any output.
- R2: The size code selects N: 2'b00 gives 8 bits, 2'b01 gives 16, 2'b10 gives 32 and 2'b11 gives 64.
- R3: The carry flag is 1 when the operand, truncated to N bits, is nonzero, and 0 when it is zero.
- R4: The overflow flag is 1 only when the truncated operand has bit N-1 set and every other bit clear.
- R5: The zero flag is 1 exactly when the N-bit result is all zeros.
- R6: The sign flag equals bit N-1 of the result.
- R7: The parity flag is 1 when result bits 7..0 hold an even number of ones, at every size.
- R8: The auxiliary flag is 1 when bit 4 of the result differs from bit 4 of the operand.
- R9: A request sampled at rising edge k produces outValid high for exactly the cycle after edge k+1, with its result and flags. Requests on consecutive cycles produce results on consecutive cycles, in order.
- R10: While no new result is published, the result and flag outputs keep their last values and outValid stays low.
- R11: A synchronous active-high reset drives outValid, the result and all flags to zero and discards any request in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Request strobe |
| inSize | input | 2 | Operand size code (R2) |
| inOperand | input | 64 | Operand; bits above the size are ignored |
| outValid | output | 1 | One-cycle pulse marking a new result |
| outResult | output | 64 | Negated value, zero-extended |
| carryOut | output | 1 | Operand was nonzero |
| overflowOut | output | 1 | Operand was the most negative value |
| zeroOut | output | 1 | Result is zero |
| signOut | output | 1 | Top bit of the result |
| parityOut | output | 1 | Even number of ones in the low result byte |
| auxOut | output | 1 | Bit 4 of result differs from bit 4 of operand |

## Verification
If the captured size code were wrong, the first result after it would show nonzero bits above the intended width, or a sign or overflow flag taken from the wrong bit. That result appears two cycles after the request. A stuck or misrouted pipeline valid would show as a missing, extra or early outValid pulse within two cycles. The scoreboard catches this as a queue mismatch or a leftover entry. A stage register that failed to hold would change the outputs during idle cycles, and the idle checks see this on the next falling edge.

// File: rtl/negflag_pkg.sv
package negflag_pkg;

  typedef struct packed {
    logic capture;
    logic publish;
  } ctrlStrobes_t;

  typedef struct packed {
    logic carry;
    logic overflow;
    logic zero;
    logic sign;
    logic parity;
    logic aux;
  } negFlags_t;

endpackage

// File: rtl/neg_ctrl.sv
module neg_ctrl
  import negflag_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  output ctrlStrobes_t strobes,
  output logic         outValid
);

  logic stageValid;

  always_ff @(posedge clk) begin
    if (rst) begin
      stageValid <= 1'b0;
      outValid   <= 1'b0;
    end else begin
      stageValid <= inValid;
      outValid   <= stageValid;
    end
  end

  always_comb begin
    strobes.capture = inValid;
    strobes.publish = stageValid;
  end

  AST_REQ_ADVANCES: assert property (@(posedge clk) disable iff (rst)
    inValid |=> stageValid); // R9
  AST_STAGE_PUBLISHES: assert property (@(posedge clk) disable iff (rst)
    stageValid |=> outValid); // R9
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
    !stageValid |=> !outValid); // R10

endmodule

// File: rtl/neg_datapath.sv
module neg_datapath
  import negflag_pkg::*;
#(
  parameter int SIZE_W = 2,
  localparam int LANES  = 1 << SIZE_W,
  localparam int DATA_W = 8 << (LANES - 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      strobes,
  input  logic [SIZE_W-1:0] inSize,
  input  logic [DATA_W-1:0] inOperand,
  output logic [DATA_W-1:0] resultQ,
  output negFlags_t         flagsQ
);

  logic [SIZE_W-1:0] sizeStage;
  logic [DATA_W-1:0] opStage;

  logic [DATA_W-1:0] laneRes   [LANES];
  negFlags_t         laneFlags [LANES];

  always_ff @(posedge clk) begin
    if (rst) begin
      sizeStage <= '0;
      opStage   <= '0;
    end else if (strobes.capture) begin
      sizeStage <= inSize;
      opStage   <= inOperand;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    localparam int LW = 8 << g;
    localparam logic [DATA_W-1:0] LANE_MASK = {DATA_W{1'b1}} >> (DATA_W - LW);
    localparam logic [DATA_W-1:0] TOP_BIT   = DATA_W'(1) << (LW - 1);

    logic [DATA_W-1:0] opTrunc;
    logic [DATA_W-1:0] negTrunc;

    always_comb begin
      opTrunc  = opStage & LANE_MASK;
      negTrunc = (DATA_W'(0) - opTrunc) & LANE_MASK;
      laneRes[g]            = negTrunc;
      laneFlags[g].carry    = |opTrunc;
      laneFlags[g].overflow = (opTrunc == TOP_BIT);
      laneFlags[g].zero     = ~|negTrunc;
      laneFlags[g].sign     = |(negTrunc & TOP_BIT);
      laneFlags[g].parity   = ~^negTrunc[7:0];
      laneFlags[g].aux      = negTrunc[4] ^ opTrunc[4];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resultQ <= '0;
      flagsQ  <= '0;
    end else if (strobes.publish) begin
      resultQ <= laneRes[sizeStage];
      flagsQ  <= laneFlags[sizeStage];
    end
  end

  AST_ZERO_MATCHES_RESULT: assert property (@(posedge clk) disable iff (rst)
    strobes.publish |=> (flagsQ.zero == (resultQ == '0))); // R5
  AST_CARRY_OPPOSES_ZERO: assert property (@(posedge clk) disable iff (rst)
    strobes.publish |=> (flagsQ.carry != flagsQ.zero)); // R3
  AST_OVERFLOW_IMPLIES_SIGN: assert property (@(posedge clk) disable iff (rst)
    strobes.publish |=> (!flagsQ.overflow || (flagsQ.sign && flagsQ.carry))); // R4
  AST_PARITY_LOW_BYTE: assert property (@(posedge clk) disable iff (rst)
    strobes.publish |=> (flagsQ.parity == ~^resultQ[7:0])); // R7
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
    !strobes.publish |=> ($stable(resultQ) && $stable(flagsQ))); // R10

endmodule

// File: rtl/neg_flag_unit.sv
module neg_flag_unit
  import negflag_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  input  logic [1:0]  inSize,
  input  logic [63:0] inOperand,
  output logic        outValid,
  output logic [63:0] outResult,
  output logic        carryOut,
  output logic        overflowOut,
  output logic        zeroOut,
  output logic        signOut,
  output logic        parityOut,
  output logic        auxOut
);

  ctrlStrobes_t strobes;
  negFlags_t    flagsQ;

  neg_ctrl ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strobes  (strobes),
    .outValid (outValid)
  );

  neg_datapath #(.SIZE_W(2)) dp_i (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .inSize    (inSize),
    .inOperand (inOperand),
    .resultQ   (outResult),
    .flagsQ    (flagsQ)
  );

  assign carryOut    = flagsQ.carry;
  assign overflowOut = flagsQ.overflow;
  assign zeroOut     = flagsQ.zero;
  assign signOut     = flagsQ.sign;
  assign parityOut   = flagsQ.parity;
  assign auxOut      = flagsQ.aux;

endmodule

// File: tb/neg_flag_unit_tb_top.sv
module neg_flag_unit_tb_top;

  typedef struct packed {
    logic [63:0] res;
    logic cf, of, zf, sf, pf, af;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [1:0]  inSize = 2'b00;
  logic [63:0] inOperand = '0;
  logic        outValid;
  logic [63:0] outResult;
  logic        carryOut, overflowOut, zeroOut, signOut, parityOut, auxOut;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  expItem_t expQ[$];
  expItem_t lastExp = '0;
  logic [63:0] lfsr = 64'h9E37_79B9_7F4A_7C15;

  always #2 clk = ~clk;

  neg_flag_unit dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .inSize(inSize), .inOperand(inOperand),
    .outValid(outValid), .outResult(outResult), .carryOut(carryOut),
    .overflowOut(overflowOut), .zeroOut(zeroOut), .signOut(signOut),
    .parityOut(parityOut), .auxOut(auxOut)
  );

  function automatic expItem_t model(logic [1:0] sz, logic [63:0] op);
    expItem_t e;
    int w = 8 << sz;
    logic [63:0] m = '0;
    logic [63:0] opm;
    int ones = 0;
    for (int i = 0; i < w; i++) m[i] = 1'b1;
    opm   = op & m;
    e.res = (~opm + 64'd1) & m;
    e.cf  = (opm != 0);
    e.of  = (opm == (64'd1 << (w - 1)));
    e.zf  = (e.res == 0);
    e.sf  = e.res[w-1];
    for (int i = 0; i < 8; i++) ones += int'(e.res[i]);
    e.pf  = (ones % 2 == 0);
    e.af  = (e.res[4] != op[4]);
    return e;
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compareOut(expItem_t e, string ctx);
    chk(outResult == e.res, {ctx, " R1 R2 result"}, outResult, e.res);
    chk(carryOut == e.cf, {ctx, " R3 carry"}, 64'(carryOut), 64'(e.cf));
    chk(overflowOut == e.of, {ctx, " R4 overflow"}, 64'(overflowOut), 64'(e.of));
    chk(zeroOut == e.zf, {ctx, " R5 zero"}, 64'(zeroOut), 64'(e.zf));
    chk(signOut == e.sf, {ctx, " R6 sign"}, 64'(signOut), 64'(e.sf));
    chk(parityOut == e.pf, {ctx, " R7 parity"}, 64'(parityOut), 64'(e.pf));
    chk(auxOut == e.af, {ctx, " R8 aux"}, 64'(auxOut), 64'(e.af));
  endtask

  task automatic send(logic [1:0] sz, logic [63:0] op);
    @(negedge clk);
    inValid   = 1'b1;
    inSize    = sz;
    inOperand = op;
    expQ.push_back(model(sz, op));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid   = 1'b0;
      inOperand = ~inOperand;
      inSize    = inSize + 2'd1;
    end
  endtask

  // Monitor: compares each published result against the scoreboard (R9 ordering).
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && outValid) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R9 unexpected outValid", 64'd1, 64'd0);
        end else begin
          lastExp = expQ.pop_front();
          compareOut(lastExp, "scoreboard");
        end
      end
    end
  end

  initial begin
    #(4 * 100000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(outValid == 0, "R11 outValid after reset", 64'(outValid), 0);
    compareOut('0, "R11 reset");
    rst = 1'b0;

    // R3 R5: zero operand at every size, upper garbage ignored (R1)
    for (int s = 0; s < 4; s++) send(2'(s), 64'h0);
    send(2'b00, 64'hFFFF_FFFF_FFFF_FF00);
    send(2'b01, 64'hABCD_0000_0000_0000);
    // R4: most negative value per size
    send(2'b00, 64'h80);
    send(2'b01, 64'h8000);
    send(2'b10, 64'h8000_0000);
    send(2'b11, 64'h8000_0000_0000_0000);
    send(2'b00, 64'hFFFF_FF80);
    // R6 R7 R8: ones and all-ones
    for (int s = 0; s < 4; s++) send(2'(s), 64'h1);
    for (int s = 0; s < 4; s++) send(2'(s), '1);
    send(2'b10, 64'h10);
    send(2'b11, 64'h0000_0001_0000_0000);
    idle(4);
    chk(expQ.size() == 0, "R9 queue drained", 64'(expQ.size()), 0);

    // R10: hold while idle
    chk(outValid == 0, "R10 outValid low when idle", 64'(outValid), 0);
    compareOut(lastExp, "R10 hold");
    idle(5);
    compareOut(lastExp, "R10 hold later");

    // Spaced requests, two-cycle latency (R9)
    send(2'b01, 64'h1234);
    idle(1);
    chk(outValid == 0, "R9 not yet valid", 64'(outValid), 0);
    @(negedge clk);
    chk(outValid == 1, "R9 valid after two edges", 64'(outValid), 1);
    idle(3);

    // Pseudo-random back-to-back requests
    for (int i = 0; i < 200; i++) begin
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 7);
      lfsr = lfsr ^ (lfsr << 17);
      send(lfsr[1:0], lfsr);
    end
    idle(4);
    chk(expQ.size() == 0, "R9 back-to-back drained", 64'(expQ.size()), 0);

    // R11: reset with a request in flight
    send(2'b11, 64'h5);
    @(negedge clk);
    inValid = 1'b0;
    rst = 1'b1;
    expQ.delete();
    @(negedge clk);
    @(negedge clk);
    chk(outValid == 0, "R11 in-flight discarded", 64'(outValid), 0);
    compareOut('0, "R11 mid-run reset");
    rst = 1'b0;
    idle(3);
    chk(outValid == 0, "R11 nothing emerges after reset", 64'(outValid), 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule